// File: doc/BRIEF.md
# USB Host Suspend and Resume Sequencer

This block owns the power-state sequence of one USB host port. It watches the software start-of-frame enable and resume request, the decoded bus line state and a millisecond tick. From these it decides whether the frame generator may emit start-of-frame packets and whether the transceiver must drive a K state downstream. Clearing the start-of-frame enable stops frames and parks the port in Suspended. The block then counts milliseconds until the attached device can be taken as asleep.

While the port is suspended, any activity on the line is latched as a wake-up event. A K state is also latched as an upstream resume. Software answers with a resume request, which is honoured only when start-of-frame is enabled at that moment. The block then drives K for the programmed resume time, releases the bus and returns to Ready with frames running. The block also holds the device address register, which a bus reset forces back to the default address 0.

Top module: `usbh_susp_seq`

## Requirements
- R1: After reset the block is in Ready. `sof_permit_o`=1, `drive_k_o`=0, both flags are 0, `irq_o`=0, `susp_done_o`=0 and `dev_addr_o`=0.
- R2: A cycle with `addr_wr_i`=1 loads `addr_wdata_i` into `dev_addr_o` one cycle later. A cycle with `bus_reset_i`=1 makes `dev_addr_o` zero one cycle later, and this wins over a write in the same cycle.
- R3: In Ready, a cycle with `sof_en_i`=0 moves the block to Suspended, so `sof_permit_o` is 0 from the next cycle on.
- R4: In Suspended, `susp_done_o` stays 0 through the first SUSP_MS ms ticks. It is 1 from the cycle after tick number SUSP_MS+1, and it stays 1 until the block leaves Suspended.
- R5: Line-state codes are 00 idle, 01 J, 10 K and 11 SE0. In Suspended, any code other than 00 sets `wake_flag_o` one cycle later.
- R6: In Suspended, code 10 (K) also sets `rsm_flag_o` one cycle later, and codes 01 and 11 do not set it. In Ready or Resuming the line state sets neither flag.
- R7: In Suspended, a cycle with `resume_req_i`=1 and `sof_en_i`=1 moves the block to Resuming. From the next cycle `drive_k_o`=1 and `sof_permit_o`=0.
- R8: A resume request while `sof_en_i`=0 has no effect: `drive_k_o` stays 0 and the block stays Suspended. Raising `sof_en_i` without a resume request also leaves the block Suspended.
- R9: In Resuming, `drive_k_o` stays 1 through the first RESUME_MS ms ticks. The cycle after tick number RESUME_MS+1, `drive_k_o` is 0 and `sof_permit_o` is 1 (Ready).
- R10: In Resuming, a cycle with `sof_en_i`=0 aborts to Suspended: one cycle later `drive_k_o`=0 and `sof_permit_o`=0.
- R11: The flags are sticky. `irq_clr_i[0]` clears `wake_flag_o` and `irq_clr_i[1]` clears `rsm_flag_o` one cycle later. A set condition in the same cycle wins over the clear.
- R12: `irq_o` is 1 exactly when (`wake_flag_o` and `irq_en_i[0]`) or (`rsm_flag_o` and `irq_en_i[1]`).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sof_en_i | input | 1 | Software start-of-frame enable (level) |
| resume_req_i | input | 1 | Software downstream-resume request (strobe) |
| bus_reset_i | input | 1 | Host issued a bus reset (strobe) |
| addr_wr_i | input | 1 | Device address write strobe |
| addr_wdata_i | input | ADDR_W | Device address write data |
| line_state_i | input | 2 | Decoded line state: 00 idle, 01 J, 10 K, 11 SE0 |
| ms_tick_i | input | 1 | One-cycle millisecond pulse |
| irq_clr_i | input | 2 | Write-one-to-clear: bit 0 wake, bit 1 resume-received |
| irq_en_i | input | 2 | Interrupt enables: bit 0 wake, bit 1 resume-received |
| sof_permit_o | output | 1 | Frame generator may send start-of-frame |
| drive_k_o | output | 1 | Transceiver drives K downstream |
| susp_done_o | output | 1 | Bus has been idle long enough to be fully suspended |
| wake_flag_o | output | 1 | Sticky bus wake-up flag |
| rsm_flag_o | output | 1 | Sticky upstream-resume flag |
| irq_o | output | 1 | Combined enabled interrupt |
| dev_addr_o | output | ADDR_W | Current device address |

## Verification
Every registered result (state-derived permits, the flags, the address and the suspend-done indication) is due one clock edge after the input cycle that causes it. The bench drives each input on the falling edge and compares on the next falling edge. Timed results (suspend done, end of the resume drive) are due on the edge that samples the deciding tick. The bench therefore checks both the cycle after the last tick that must not yet act and the cycle after the tick that must. `irq_o` follows the flags and enables within the same cycle, so it is compared in the same sample as the flags.

// File: rtl/usbh_susp_pkg.sv
// Shared definitions for the USB host suspend/resume sequencer.
// Assumes line-state codes come from an already synchronised decoder.
package usbh_susp_pkg;

    typedef enum logic [1:0] {
        ST_READY  = 2'd0,
        ST_SUSP   = 2'd1,
        ST_RESUME = 2'd2
    } host_st_e;

    localparam logic [1:0] LS_IDLE = 2'b00;
    localparam logic [1:0] LS_J    = 2'b01;
    localparam logic [1:0] LS_K    = 2'b10;
    localparam logic [1:0] LS_SE0  = 2'b11;

    localparam int FLAG_WAKE = 0;
    localparam int FLAG_RSM  = 1;
    localparam int NFLAGS    = 2;

endpackage

// File: rtl/usbh_ms_timer.sv
// Millisecond interval counter.
// Counts single-cycle ms ticks since the last clear and saturates at LIMIT.
// A clear in the same cycle as a tick wins. Assumes ticks are one cycle wide.
module usbh_ms_timer #(
    parameter int LIMIT = 21,
    localparam int CW   = $clog2(LIMIT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    input  logic          tick_i,
    output logic [CW-1:0] cnt_o
);
    localparam logic [CW-1:0] LIM = CW'(LIMIT);

    logic [CW-1:0] cnt_q;

    // Count ticks, restart on clear, hold at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (clr_i)
            cnt_q <= '0;
        else if (tick_i && cnt_q != LIM)
            cnt_q <= cnt_q + 1'b1;
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/usbh_wake_flags.sv
// Sticky interrupt flags with write-one-to-clear and per-flag enables.
// A set condition wins over a clear in the same cycle. The combined
// interrupt is the OR of enabled flags, decoded from the flag registers.
module usbh_wake_flags #(
    parameter int NF = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NF-1:0] set_i,
    input  logic [NF-1:0] clr_i,
    input  logic [NF-1:0] en_i,
    output logic [NF-1:0] flag_o,
    output logic          irq_o
);
    logic [NF-1:0] flag_q;

    for (genvar g = 0; g < NF; g++) begin : g_flag
        // One sticky flag: set has priority, then clear, else hold.
        always_ff @(posedge clk) begin
            if (!rst_n)
                flag_q[g] <= 1'b0;
            else if (set_i[g])
                flag_q[g] <= 1'b1;
            else if (clr_i[g])
                flag_q[g] <= 1'b0;
        end
    end

    assign flag_o = flag_q;
    assign irq_o  = |(flag_q & en_i);
endmodule

// File: rtl/usbh_addr_reg.sv
// Device address register of the host port.
// Loads on a write strobe; a bus reset returns it to the default address 0
// and takes priority over a write in the same cycle.
module usbh_addr_reg #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_i,
    input  logic [W-1:0] wdata_i,
    input  logic         bus_reset_i,
    output logic [W-1:0] addr_o
);
    logic [W-1:0] addr_q;

    // Hold the address, clear on bus reset, load on write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            addr_q <= '0;
        else if (bus_reset_i)
            addr_q <= '0;
        else if (wr_i)
            addr_q <= wdata_i;
    end

    assign addr_o = addr_q;
endmodule

// File: rtl/usbh_susp_seq.sv
// USB host suspend/resume sequencer (top).
// Sequences Ready -> Suspended -> Resuming -> Ready. The state machine
// is steered by the start-of-frame enable, the resume request and ms ticks.
// Latches wake-up and upstream-resume events seen while suspended.
// Assumes line_state_i is synchronised and ms_tick_i is a one-cycle pulse.
module usbh_susp_seq
    import usbh_susp_pkg::*;
#(
    parameter int ADDR_W    = 7,
    parameter int SUSP_MS   = 3,
    parameter int RESUME_MS = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sof_en_i,
    input  logic              resume_req_i,
    input  logic              bus_reset_i,
    input  logic              addr_wr_i,
    input  logic [ADDR_W-1:0] addr_wdata_i,
    input  logic [1:0]        line_state_i,
    input  logic              ms_tick_i,
    input  logic [1:0]        irq_clr_i,
    input  logic [1:0]        irq_en_i,
    output logic              sof_permit_o,
    output logic              drive_k_o,
    output logic              susp_done_o,
    output logic              wake_flag_o,
    output logic              rsm_flag_o,
    output logic              irq_o,
    output logic [ADDR_W-1:0] dev_addr_o
);
    localparam int CNT_LIMIT = ((SUSP_MS > RESUME_MS) ? SUSP_MS : RESUME_MS) + 1;
    localparam int CNT_W     = $clog2(CNT_LIMIT + 1);
    localparam logic [CNT_W-1:0] SUSP_CMP = CNT_W'(SUSP_MS);
    localparam logic [CNT_W-1:0] RES_CMP  = CNT_W'(RESUME_MS);

    host_st_e         state_q, state_d;
    logic [CNT_W-1:0] ms_cnt;
    logic             in_susp;
    logic             state_chg;
    logic [NFLAGS-1:0] flag_set, flag_val;

    // Next-state decision for the port power sequence.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_READY:  if (!sof_en_i) state_d = ST_SUSP;
            ST_SUSP:   if (resume_req_i && sof_en_i) state_d = ST_RESUME;
            ST_RESUME: begin
                if (!sof_en_i)
                    state_d = ST_SUSP;
                else if (ms_tick_i && ms_cnt == RES_CMP)
                    state_d = ST_READY;
            end
            default:   state_d = ST_READY;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_READY;
        else
            state_q <= state_d;
    end

    assign in_susp   = (state_q == ST_SUSP);
    assign state_chg = (state_d != state_q);

    usbh_ms_timer #(.LIMIT(CNT_LIMIT)) i_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (state_chg),
        .tick_i (ms_tick_i),
        .cnt_o  (ms_cnt)
    );

    // Wake-up event decode: activity while suspended; K means upstream resume.
    always_comb begin
        flag_set            = '0;
        flag_set[FLAG_WAKE] = in_susp && (line_state_i != LS_IDLE);
        flag_set[FLAG_RSM]  = in_susp && (line_state_i == LS_K);
    end

    usbh_wake_flags #(.NF(NFLAGS)) i_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (flag_set),
        .clr_i  (irq_clr_i),
        .en_i   (irq_en_i),
        .flag_o (flag_val),
        .irq_o  (irq_o)
    );

    usbh_addr_reg #(.W(ADDR_W)) i_addr (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_i        (addr_wr_i),
        .wdata_i     (addr_wdata_i),
        .bus_reset_i (bus_reset_i),
        .addr_o      (dev_addr_o)
    );

    assign wake_flag_o  = flag_val[FLAG_WAKE];
    assign rsm_flag_o   = flag_val[FLAG_RSM];
    assign sof_permit_o = (state_q == ST_READY);
    assign drive_k_o    = (state_q == ST_RESUME);
    assign susp_done_o  = in_susp && (ms_cnt > SUSP_CMP);
endmodule

// File: rtl/usbh_susp_seq_chk.sv
// Property checker for the suspend/resume sequencer, bound to the top.
// Observes ports only, plus its own count of ms ticks during the K drive.
module usbh_susp_seq_chk #(
    parameter int ADDR_W    = 7,
    parameter int RESUME_MS = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sof_en_i,
    input logic              bus_reset_i,
    input logic [1:0]        line_state_i,
    input logic              ms_tick_i,
    input logic [1:0]        irq_clr_i,
    input logic              sof_permit_o,
    input logic              drive_k_o,
    input logic              susp_done_o,
    input logic              wake_flag_o,
    input logic              rsm_flag_o,
    input logic [ADDR_W-1:0] dev_addr_o
);
    localparam int KW = $clog2(RESUME_MS + 3);
    localparam logic [KW-1:0] K_MAX = KW'(RESUME_MS + 2);
    localparam logic [KW-1:0] K_MIN = KW'(RESUME_MS);

    logic [KW-1:0] k_ticks;
    logic          suspended;

    // Count ms ticks seen while K is being driven.
    always_ff @(posedge clk) begin
        if (!rst_n)
            k_ticks <= '0;
        else if (!drive_k_o)
            k_ticks <= '0;
        else if (ms_tick_i && k_ticks != K_MAX)
            k_ticks <= k_ticks + 1'b1;
    end

    assign suspended = !sof_permit_o && !drive_k_o;

    p_addr_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_reset_i |=> (dev_addr_o == '0));

    p_sof_stop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !sof_en_i |=> !sof_permit_o);

    p_done_susp_r4: assert property (@(posedge clk) disable iff (!rst_n)
        susp_done_o |-> suspended);

    p_wake_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (suspended && line_state_i != 2'b00) |=> wake_flag_o);

    p_rsm_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (suspended && line_state_i == 2'b10) |=> rsm_flag_o);

    p_resume_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (suspended && !sof_en_i) |=> !drive_k_o);

    p_k_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(drive_k_o) && sof_permit_o) |-> (k_ticks > K_MIN));

    p_wake_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_flag_o && !irq_clr_i[0]) |=> wake_flag_o);

    p_rsm_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rsm_flag_o && !irq_clr_i[1]) |=> rsm_flag_o);
endmodule

bind usbh_susp_seq usbh_susp_seq_chk #(
    .ADDR_W    (ADDR_W),
    .RESUME_MS (RESUME_MS)
) i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sof_en_i     (sof_en_i),
    .bus_reset_i  (bus_reset_i),
    .line_state_i (line_state_i),
    .ms_tick_i    (ms_tick_i),
    .irq_clr_i    (irq_clr_i),
    .sof_permit_o (sof_permit_o),
    .drive_k_o    (drive_k_o),
    .susp_done_o  (susp_done_o),
    .wake_flag_o  (wake_flag_o),
    .rsm_flag_o   (rsm_flag_o),
    .dev_addr_o   (dev_addr_o)
);

// File: tb/test_usbh_susp_seq.sv
// Self-checking bench: a vector table walked by one loop, then directed
// tests for timing windows, priority corners and reset.
module test_usbh_susp_seq;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 7;
    localparam int SUSP_MS    = 3;
    localparam int RESUME_MS  = 20;
    localparam int WATCHDOG   = 20000;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              sof_en_i, resume_req_i, bus_reset_i, addr_wr_i;
    logic [ADDR_W-1:0] addr_wdata_i;
    logic [1:0]        line_state_i, irq_clr_i, irq_en_i;
    logic              ms_tick_i;
    logic              sof_permit_o, drive_k_o, susp_done_o;
    logic              wake_flag_o, rsm_flag_o, irq_o;
    logic [ADDR_W-1:0] dev_addr_o;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    usbh_susp_seq #(
        .ADDR_W(ADDR_W), .SUSP_MS(SUSP_MS), .RESUME_MS(RESUME_MS)
    ) i_usbh_susp_seq (
        .clk(clk), .rst_n(rst_n), .sof_en_i(sof_en_i),
        .resume_req_i(resume_req_i), .bus_reset_i(bus_reset_i),
        .addr_wr_i(addr_wr_i), .addr_wdata_i(addr_wdata_i),
        .line_state_i(line_state_i), .ms_tick_i(ms_tick_i),
        .irq_clr_i(irq_clr_i), .irq_en_i(irq_en_i),
        .sof_permit_o(sof_permit_o), .drive_k_o(drive_k_o),
        .susp_done_o(susp_done_o), .wake_flag_o(wake_flag_o),
        .rsm_flag_o(rsm_flag_o), .irq_o(irq_o), .dev_addr_o(dev_addr_o)
    );

    typedef struct packed {
        logic       sof;
        logic       rsm;
        logic       brst;
        logic       aw;
        logic [6:0] ad;
        logic [1:0] ls;
        logic [1:0] clr;
        logic [1:0] en;
        logic [5:0] e_ctl;   // {permit, drive_k, wake, rsm, irq, done}
        logic [6:0] e_addr;
        logic [3:0] tag;
    } vec_t;

    // Each row: inputs held for one cycle, outputs expected one edge later.
    localparam vec_t VEC [0:14] = '{
        '{1,0,0,1,7'h2A,2'b00,2'b00,2'b00,6'b100000,7'h2A,4'd2},  // R2 write
        '{1,0,1,1,7'h11,2'b00,2'b00,2'b00,6'b100000,7'h00,4'd2},  // R2 reset wins
        '{1,0,0,1,7'h05,2'b10,2'b00,2'b11,6'b100000,7'h05,4'd6},  // R6 K in Ready
        '{1,1,0,0,7'h00,2'b11,2'b00,2'b11,6'b100000,7'h05,4'd6},  // R6 SE0 in Ready
        '{0,0,0,0,7'h00,2'b00,2'b00,2'b11,6'b000000,7'h05,4'd3},  // R3 suspend
        '{0,0,0,0,7'h00,2'b01,2'b00,2'b11,6'b001010,7'h05,4'd5},  // R5 J wakes
        '{0,0,0,0,7'h00,2'b00,2'b01,2'b10,6'b000000,7'h05,4'd11}, // R11 clear
        '{0,0,0,0,7'h00,2'b11,2'b00,2'b10,6'b001000,7'h05,4'd12}, // R12 masked
        '{0,0,0,0,7'h00,2'b10,2'b00,2'b10,6'b001110,7'h05,4'd6},  // R6 K both
        '{0,0,0,0,7'h00,2'b00,2'b11,2'b10,6'b000000,7'h05,4'd11}, // R11 clear both
        '{0,1,0,0,7'h00,2'b00,2'b00,2'b00,6'b000000,7'h05,4'd8},  // R8 gated
        '{1,0,0,0,7'h00,2'b00,2'b00,2'b00,6'b000000,7'h05,4'd8},  // R8 enable only
        '{1,1,0,0,7'h00,2'b00,2'b00,2'b00,6'b010000,7'h05,4'd7},  // R7 resume
        '{1,0,0,0,7'h00,2'b10,2'b00,2'b00,6'b010000,7'h05,4'd6},  // R6 K in Resuming
        '{0,0,0,0,7'h00,2'b00,2'b00,2'b00,6'b000000,7'h05,4'd10}  // R10 abort
    };

    task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %0h exp %0h", req, got, exp);
        end
    endtask

    task automatic idle_inputs();
        resume_req_i = 1'b0; bus_reset_i = 1'b0; addr_wr_i = 1'b0;
        addr_wdata_i = '0; line_state_i = 2'b00; ms_tick_i = 1'b0; irq_clr_i = 2'b00;
    endtask

    task automatic tick_pulse();
        ms_tick_i = 1'b1;
        @(negedge clk);
        ms_tick_i = 1'b0;
        @(negedge clk);
    endtask

    function automatic logic [15:0] ctl_now();
        return {10'd0, sof_permit_o, drive_k_o, wake_flag_o, rsm_flag_o, irq_o, susp_done_o};
    endfunction

    // Watchdog: a hung run is a failed check and still prints the summary.
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; sof_en_i = 1'b1; irq_en_i = 2'b00;
        idle_inputs();
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 ctl", ctl_now(), 16'b100000);
        check("R1 addr", 16'(dev_addr_o), 16'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk
        for (int i = 0; i < 15; i++) begin
            sof_en_i = VEC[i].sof; resume_req_i = VEC[i].rsm;
            bus_reset_i = VEC[i].brst; addr_wr_i = VEC[i].aw;
            addr_wdata_i = VEC[i].ad; line_state_i = VEC[i].ls;
            irq_clr_i = VEC[i].clr; irq_en_i = VEC[i].en;
            @(negedge clk);
            check($sformatf("R%0d row %0d", VEC[i].tag, i),
                  {ctl_now()[5:0], 3'b0, dev_addr_o},
                  {VEC[i].e_ctl, 3'b0, VEC[i].e_addr});
        end
        idle_inputs();

        // R4: suspended, counter fresh; SUSP_MS ticks are not enough
        sof_en_i = 1'b0;
        for (int t = 0; t < SUSP_MS; t++) tick_pulse();
        check("R4 early", 16'(susp_done_o), 16'h0);
        tick_pulse();
        check("R4 done", 16'(susp_done_o), 16'h1);
        tick_pulse();
        check("R4 held", 16'(susp_done_o), 16'h1);

        // R7 then R9: resume from full suspend, drive K for the window
        sof_en_i = 1'b1; resume_req_i = 1'b1;
        @(negedge clk);
        resume_req_i = 1'b0;
        check("R7 enter", ctl_now(), 16'b010000);
        for (int t = 0; t < RESUME_MS; t++) tick_pulse();
        check("R9 still K", ctl_now(), 16'b010000);
        tick_pulse();
        check("R9 back Ready", ctl_now(), 16'b100000);

        // R11: set wins over clear in the same cycle
        sof_en_i = 1'b0;
        @(negedge clk);
        line_state_i = 2'b01; irq_clr_i = 2'b01; irq_en_i = 2'b01;
        @(negedge clk);
        check("R11 set wins", ctl_now(), 16'b001010);
        line_state_i = 2'b00; irq_clr_i = 2'b00;
        @(negedge clk);
        check("R11 sticky", 16'(wake_flag_o), 16'h1);
        // R12: enable removal drops irq in the same cycle
        irq_en_i = 2'b00;
        #1;
        check("R12 unmask", 16'(irq_o), 16'h0);

        // R1: reset again from a busy state
        addr_wr_i = 1'b1; addr_wdata_i = 7'h33;
        @(negedge clk);
        addr_wr_i = 1'b0;
        check("R2 load", 16'(dev_addr_o), 16'h33);
        sof_en_i = 1'b1; rst_n = 1'b0;
        @(negedge clk);
        check("R1 re-reset", {ctl_now()[5:0], 3'b0, dev_addr_o}, 16'b100000_000_0000000);
        rst_n = 1'b1;
        @(negedge clk);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule